// File: doc/BRIEF.md
# Skewed Three-Bank Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps three banks of 2-bit saturating counters. Each bank is indexed by its own hash of the branch's instruction word address and that thread's global history. Because the three hashes differ, two branches that share an entry in one bank are unlikely to share one in the others. The block reads all three banks in parallel and returns the majority of their three taken bits as the prediction.

The lookup side is purely combinational. A fetch stage presents a word address and a thread number and reads the prediction in the same cycle. The update side takes a resolved branch: its thread, its word address and its outcome. On the clock edge it trains the counters and shifts the outcome into that thread's history register. Each thread keeps its own history register. The number of threads is a parameter. Bank depth is also a parameter, with a small default for simulation.

Top module: `skew_vote_predictor`

## Requirements
- R1: `pred_taken` is 1 exactly when at least two of the three counters selected by the lookup have a value of 2 or 3, in the same cycle as the lookup inputs.
- R2: After reset every counter holds 1 (weakly not taken) and every thread history is 0, so every lookup predicts not taken.
- R3: With W = IDX_W, a = pc[W-1:0], b = the XOR-fold of pc[PC_W-1:W] into W bits, and f = the XOR-fold of history into W bits (bit i lands on bit i mod W), the three indices are: bank 0 `a ^ f`; bank 1 `rotl(a,1) ^ rev(f) ^ b`; bank 2 `rev(a) ^ rotl(f,3) ^ rotl(b,2)`. Here rotl is a left rotation within W bits and rev is a bit reversal.
- R4: Counters saturate at 0 and 3 and never wrap.
- R5: On an update whose majority vote, formed from the counters at the update's indices with the update thread's current history, equals the outcome, only the banks whose own taken bit equals the outcome move one step toward the outcome. The other banks stay unchanged.
- R6: On an update whose majority vote differs from the outcome, all three banks move one step toward the outcome.
- R7: An update shifts its outcome into bit 0 of the selected thread's history, with older bits moving up one place. The histories of other threads do not change.
- R8: `lk_hist` shows the current history of the thread chosen by `lk_thread`, and the lookup indices use that history.
- R9: In a cycle with `upd_valid` low, no counter and no history changes.
- R10: When a lookup and an update hit the same entries in one cycle, the lookup sees the values from before the update. The new values are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Instruction word address of the branch being looked up |
| lk_thread | input | TH_W | Thread whose history the lookup uses |
| pred_taken | output | 1 | Majority prediction, 1 = taken |
| lk_hist | output | HIST_W | Current history of `lk_thread` |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_thread | input | TH_W | Thread of the resolved branch |
| upd_pc | input | PC_W | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check on every cycle that the prediction matches the majority of the three bank votes. They also check that a correct update writes at least two banks, that a misprediction writes all three, and that an idle cycle writes none. The history of the looked-up thread must either shift in the outcome or hold still. The bench's scenarios are what show the hash functions, counter saturation, and exactly which bank a partial update leaves alone. They do this by comparing every prediction with a reference model that has its own indexing. The bench is built with a 16-entry bank so that aliasing between branches is frequent.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam int   NBANKS   = 3;

  // one saturating step toward the outcome
  function automatic ctr_t ctr_next(input ctr_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/skew_index.sv
module skew_index #(
  parameter int PC_W   = 30,
  parameter int HIST_W = 15,
  parameter int IDX_W  = 10,
  parameter int BANK   = 0
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  typedef logic [IDX_W-1:0] ix_t;

  function automatic ix_t fold_hist(input logic [HIST_W-1:0] h);
    ix_t r = '0;
    for (int i = 0; i < HIST_W; i++) r[i % IDX_W] ^= h[i];
    return r;
  endfunction

  function automatic ix_t fold_high(input logic [PC_W-1:0] p);
    ix_t r = '0;
    for (int i = IDX_W; i < PC_W; i++) r[(i - IDX_W) % IDX_W] ^= p[i];
    return r;
  endfunction

  function automatic ix_t rotl(input ix_t x, input int k);
    ix_t r;
    for (int i = 0; i < IDX_W; i++) r[(i + k) % IDX_W] = x[i];
    return r;
  endfunction

  function automatic ix_t rev(input ix_t x);
    ix_t r;
    for (int i = 0; i < IDX_W; i++) r[i] = x[IDX_W-1-i];
    return r;
  endfunction

  ix_t a_lo, b_hi, h_f;
  assign a_lo = pc[IDX_W-1:0];
  assign b_hi = fold_high(pc);
  assign h_f  = fold_hist(hist);

  generate
    if (BANK == 0) begin : g_b0
      assign idx = a_lo ^ h_f;
    end else if (BANK == 1) begin : g_b1
      assign idx = rotl(a_lo, 1) ^ rev(h_f) ^ b_hi;
    end else begin : g_b2
      assign idx = rev(a_lo) ^ rotl(h_f, 3) ^ rotl(b_hi, 2);
    end
  endgenerate
endmodule

// File: rtl/skew_bank.sv
module skew_bank
  import skew_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_vote,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             wr_vote,
  input  logic             wr_en,
  input  logic             wr_up
);
  ctr_t mem [DEPTH];

  assign lk_vote = mem[lk_idx][1];
  assign wr_vote = mem[wr_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_next(mem[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/skew_vote_predictor.sv
module skew_vote_predictor
  import skew_pkg::*;
#(
  parameter int PC_W    = 30,
  parameter int HIST_W  = 15,
  parameter int IDX_W   = 10,
  parameter int THREADS = 2,
  localparam int TH_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [TH_W-1:0]   lk_thread,
  output logic              pred_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              upd_valid,
  input  logic [TH_W-1:0]   upd_thread,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken
);
  logic [HIST_W-1:0] hist_q [THREADS];
  logic [HIST_W-1:0] upd_hist;
  logic [2:0]        lk_votes, up_votes, bank_wr;
  logic              upd_pred, upd_mispred;

  assign lk_hist  = hist_q[lk_thread];
  assign upd_hist = hist_q[upd_thread];

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [IDX_W-1:0] lk_idx, up_idx;

      skew_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .BANK(b)) u_lk_ix (
        .pc(lk_pc), .hist(lk_hist), .idx(lk_idx));
      skew_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .BANK(b)) u_up_ix (
        .pc(upd_pc), .hist(upd_hist), .idx(up_idx));

      assign bank_wr[b] = upd_valid & (upd_mispred | (up_votes[b] == upd_taken));

      skew_bank #(.IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_vote(lk_votes[b]),
        .wr_idx(up_idx), .wr_vote(up_votes[b]),
        .wr_en(bank_wr[b]), .wr_up(upd_taken));
    end
  endgenerate

  assign pred_taken  = maj3(lk_votes);
  assign upd_pred    = maj3(up_votes);
  assign upd_mispred = upd_pred ^ upd_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) hist_q[t] <= '0;
    end else if (upd_valid) begin
      hist_q[upd_thread] <= {upd_hist[HIST_W-2:0], upd_taken};
    end
  end
endmodule

// File: rtl/skew_vote_predictor_chk.sv
module skew_vote_predictor_chk #(
  parameter int HIST_W = 15,
  parameter int TH_W   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TH_W-1:0]   lk_thread,
  input logic [HIST_W-1:0] lk_hist,
  input logic              pred_taken,
  input logic [2:0]        lk_votes,
  input logic              upd_valid,
  input logic [TH_W-1:0]   upd_thread,
  input logic              upd_taken,
  input logic              upd_mispred,
  input logic [2:0]        bank_wr
);
  AST_VOTE_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == ($countones(lk_votes) >= 2)); // R1

  AST_AGREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_mispred) |-> ($countones(bank_wr) >= 2)); // R5

  AST_MISS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispred) |-> (bank_wr == 3'b111)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (bank_wr == 3'b000)); // R9

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_thread == lk_thread) ##1 (lk_thread == $past(lk_thread))
      |-> lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(upd_taken)}); // R7

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_thread == lk_thread) ##1 (lk_thread == $past(lk_thread))
      |-> $stable(lk_hist)); // R9
endmodule

bind skew_vote_predictor skew_vote_predictor_chk #(.HIST_W(HIST_W), .TH_W(TH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_thread(lk_thread), .lk_hist(lk_hist),
  .pred_taken(pred_taken), .lk_votes(lk_votes), .upd_valid(upd_valid),
  .upd_thread(upd_thread), .upd_taken(upd_taken), .upd_mispred(upd_mispred),
  .bank_wr(bank_wr));

// File: tb/skew_vote_predictor_test.sv
`timescale 1ns/1ps
module skew_vote_predictor_test;
  localparam int W    = 4;
  localparam int PCW  = 16;
  localparam int H    = 15;
  localparam int MASK = (1 << W) - 1;
  localparam int HMSK = (1 << H) - 1;

  logic clk = 0, rst_n = 0;
  logic [PCW-1:0] lk_pc = '0, upd_pc = '0;
  logic lk_thread = 0, upd_thread = 0, upd_valid = 0, upd_taken = 0;
  logic pred_taken;
  logic [H-1:0] lk_hist;

  always #2.5 clk = ~clk;

  skew_vote_predictor #(.PC_W(PCW), .HIST_W(H), .IDX_W(W), .THREADS(2)) uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_thread(lk_thread),
    .pred_taken(pred_taken), .lk_hist(lk_hist), .upd_valid(upd_valid),
    .upd_thread(upd_thread), .upd_pc(upd_pc), .upd_taken(upd_taken));

  int errors = 0, checks = 0;
  int ctr_m [3][1<<W];
  int hist_m [2];
  bit done = 0;
  int unsigned lfsr = 32'h1234_5678;

  function automatic int brot(int x, int k);
    k = k % W;
    return ((x << k) | (x >> (W - k))) & MASK;
  endfunction
  function automatic int brev(int x);
    int r = 0;
    for (int i = 0; i < W; i++) if ((x >> i) & 1) r |= 1 << (W - 1 - i);
    return r;
  endfunction
  function automatic int bidx(int bank, int pc, int h);
    int a = pc & MASK, f = 0, g = 0, p = pc >> W;
    for (int s = 0; s < H; s += W) f ^= (h >> s) & MASK;
    for (int s = 0; s < PCW - W; s += W) g ^= (p >> s) & MASK;
    if (bank == 0) return a ^ f;
    if (bank == 1) return brot(a, 1) ^ brev(f) ^ g;
    return brev(a) ^ brot(f, 3) ^ brot(g, 2);
  endfunction
  function automatic int mpred(int pc, int h);
    int n = 0;
    for (int b = 0; b < 3; b++) if (ctr_m[b][bidx(b, pc, h)] >= 2) n++;
    return (n >= 2) ? 1 : 0;
  endfunction
  function automatic int rnd();
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr & 32'h7fff_ffff);
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one cycle, check lookup before the edge, then advance the model
  task automatic step(string tag, int lth, int lpc, int uv, int uth, int upc, int ut);
    @(negedge clk);
    lk_thread = lth[0]; lk_pc = lpc[PCW-1:0];
    upd_valid = uv[0]; upd_thread = uth[0]; upd_pc = upc[PCW-1:0]; upd_taken = ut[0];
    #1;
    check(tag, int'(pred_taken), mpred(lpc, hist_m[lth]));
    check(tag, int'(lk_hist), hist_m[lth]);
    @(posedge clk);
    if (uv != 0) begin
      int h = hist_m[uth];
      int p = mpred(upc, h);
      for (int b = 0; b < 3; b++) begin
        int ix = bidx(b, upc, h);
        int v  = (ctr_m[b][ix] >= 2) ? 1 : 0;
        if (p != ut || v == ut) begin
          if (ut != 0 && ctr_m[b][ix] < 3) ctr_m[b][ix]++;
          if (ut == 0 && ctr_m[b][ix] > 0) ctr_m[b][ix]--;
        end
      end
      hist_m[uth] = ((h << 1) | ut) & HMSK;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) begin
      step("R2", i % 2, rnd(), 0, 0, 0, 0);
      check("R2", int'(pred_taken), 0);
    end
  endtask

  task automatic t_hist();
    step("R7", 0, 5, 1, 0, 5, 1);
    step("R7", 0, 5, 1, 0, 9, 1);
    step("R7", 1, 5, 1, 0, 9, 0);
    step("R7", 1, 5, 1, 1, 3, 1);
    step("R8", 0, 5, 0, 0, 0, 0);
    check("R8", int'(lk_hist), 6);
    step("R8", 1, 5, 0, 0, 0, 0);
    check("R8", int'(lk_hist), 1);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 8; i++) begin
      int pc = 16'h0a30 + i;
      step("R10", 0, pc, 1, 0, pc, 1);
      step("R10", 0, pc, 0, 0, 0, 0);
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 30; i++) step("R4", 1, 16'h0777, 1, 1, 16'h0777, 1);
    check("R4", int'(pred_taken), 1);
    step("R4", 1, 16'h0777, 1, 1, 16'h0777, 0);
    check("R4", int'(pred_taken), 1);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 40; i++) step("R9", i % 2, rnd(), 0, 1, rnd(), 1);
  endtask

  task automatic t_alias();
    for (int i = 0; i < 300; i++) begin
      int pc = rnd() & 16'h00ff;
      step("R3", rnd() % 2, pc, 1, rnd() % 2, pc ^ 16'h0100, rnd() % 2);
    end
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 1500; i++) begin
      int pcs [6] = '{16'h1000, 16'h2345, 16'h0011, 16'hbeef, 16'h4010, 16'h7777};
      int up = pcs[rnd() % 6];
      step("R1 R5 R6", rnd() % 2, pcs[rnd() % 6], (rnd() % 4) != 0, rnd() % 2, up,
           ((rnd() % 5) < 3) ? (up & 1) : 1 - (up & 1));
    end
  endtask

  initial begin
    for (int b = 0; b < 3; b++) for (int i = 0; i < (1 << W); i++) ctr_m[b][i] = 1;
    hist_m[0] = 0; hist_m[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_hist();
    t_same_cycle();
    t_saturate();
    t_idle();
    t_alias();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule